// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Memory Target

This block is a memory target on a shared 32-bit bus whose lines carry the address first and the data after it. In the address cycle an initiator raises a request strobe and a read/write command bit, and it puts a byte address on the bus lines. For a read, the target leaves the lines undriven while it fetches one 64-bit word from its internal storage. It then drives the word back as two 32-bit beats and marks each beat as valid. For a write, the initiator sends two 32-bit data beats in the cycles after the address. The target stores the assembled word and signals completion.

Every transaction has a fixed length, so an initiator can plan bus ownership in advance. A read takes eight bus cycles from the address to the last data beat. A write takes four cycles, counting its acknowledge cycle. Only one transaction runs at a time. A busy flag covers the whole transaction, and any request raised while the flag is set is dropped.

Top module: `mux_bus_mem_target`

## Requirements
- R1: While reset is high, and in the first cycle after it, busy, rd_valid, done and ad_oe are all low.
- R2: If req is high at a clock edge while busy is low, the target accepts a transaction and samples ad_in as the address and cmd_wr as the command (1 = write, 0 = read). The accepting edge ends cycle 0. busy is high from cycle 1 until the transaction ends.
- R3: The word addressed is ad_in bits [6:3], the byte address divided by eight, for the default 16 words. Address bits 2:0 and all bits above bit 6 are ignored, so addresses that differ only in those bits reach the same word.
- R4: A read leaves rd_valid low in cycles 1 to 5, delivers data beats in cycles 6 and 7, and has busy low again in cycle 8. The read therefore takes eight cycles.
- R5: The first read beat carries bits 31:0 of the stored word and the second beat carries bits 63:32. rd_valid is high during both beats.
- R6: done is high for exactly one cycle per transaction. For a read this is cycle 7, the second beat. For a write it is cycle 3.
- R7: A write takes ad_in in cycle 1 as bits 31:0 and ad_in in cycle 2 as bits 63:32. The new word replaces the stored word, a later read returns it, and busy is low again in cycle 4.
- R8: ad_oe is high only during the two read data beats. Outside those beats the target does not drive the bus, which leaves turnaround cycles around the initiator's address and data.
- R9: A req raised while busy is high is ignored, whatever the command or address. It changes neither the timing of the current transaction nor any stored word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, valid in the address cycle |
| cmd_wr | input | 1 | Command: 1 = write, 0 = read |
| ad_in | input | 32 | Multiplexed address/data lines as driven by the initiator |
| ad_out | output | 32 | Read data driven by the target |
| ad_oe | output | 1 | Target drives the shared lines |
| rd_valid | output | 1 | Read data beat valid |
| done | output | 1 | Transaction completion pulse |
| busy | output | 1 | Transaction in progress; new requests ignored |

## Verification
The hardest cases to reach are requests that arrive while a transaction is already running. They can arrive during the silent access window of a read, or during the data beats of a write, when the same lines carry data that looks like an address. The stimulus injects write requests into reads and read requests into write data cycles, sometimes with an address aimed at a word that has already been written. It then reads that word back to confirm that nothing changed. Random transactions use random aliased addresses, which also exercises the ignored address bits.

// File: rtl/mbt_pkg.sv
`timescale 1ns/1ps
package mbt_pkg;

  // Bus-side phases of one transaction.
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WAIT   = 3'd1,  // storage access window of a read
    ST_RD_LO  = 3'd2,  // low beat on the bus
    ST_RD_HI  = 3'd3,  // high beat on the bus
    ST_WR_LO  = 3'd4,  // initiator drives low data half
    ST_WR_HI  = 3'd5,  // initiator drives high data half
    ST_WR_ACK = 3'd6   // completion cycle of a write
  } mbt_state_e;

endpackage

// File: rtl/mbt_seq.sv
`timescale 1ns/1ps
// Transaction sequencer. ACCESS_CYC must be at least 2, so that the
// storage read data settles before the first beat is loaded.
module mbt_seq
  import mbt_pkg::*;
#(
  parameter int ACCESS_CYC = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic       cmd_wr,
  output mbt_state_e state,
  output mbt_state_e state_nx,
  output logic       accept
);

  localparam int CW = $clog2(ACCESS_CYC + 1);
  localparam logic [CW-1:0] LAST_WAIT = CW'(ACCESS_CYC - 1);

  logic [CW-1:0] wait_cnt;

  always_comb begin
    state_nx = state;
    accept   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (req) begin
          accept   = 1'b1;
          state_nx = cmd_wr ? ST_WR_LO : ST_WAIT;
        end
      end
      ST_WAIT:   if (wait_cnt == LAST_WAIT) state_nx = ST_RD_LO;
      ST_RD_LO:  state_nx = ST_RD_HI;
      ST_RD_HI:  state_nx = ST_IDLE;
      ST_WR_LO:  state_nx = ST_WR_HI;
      ST_WR_HI:  state_nx = ST_WR_ACK;
      ST_WR_ACK: state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      wait_cnt <= '0;
    end else begin
      state <= state_nx;
      if (state == ST_WAIT) wait_cnt <= wait_cnt + 1'b1;
      else                  wait_cnt <= '0;
    end
  end

endmodule

// File: rtl/mbt_word_ram.sv
`timescale 1ns/1ps
// Single-port synchronous word store, read-first, no reset on the array.
module mbt_word_ram #(
  parameter int WORD_W = 64,
  parameter int DEPTH  = 16,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[idx] <= wdata;
      rdata <= mem[idx];
    end
  end

endmodule

// File: rtl/mbt_bus_stage.sv
`timescale 1ns/1ps
// Registered bus-facing outputs, loaded from the sequencer's next state.
module mbt_bus_stage
  import mbt_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int WORD_W = 2 * BUS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  mbt_state_e        state_nx,
  input  logic [WORD_W-1:0] word,
  output logic [BUS_W-1:0]  ad_out,
  output logic              ad_oe,
  output logic              rd_valid,
  output logic              done,
  output logic              busy
);

  logic beat_lo, beat_hi;

  always_comb begin
    beat_lo = (state_nx == ST_RD_LO);
    beat_hi = (state_nx == ST_RD_HI);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ad_out   <= '0;
      ad_oe    <= 1'b0;
      rd_valid <= 1'b0;
      done     <= 1'b0;
      busy     <= 1'b0;
    end else begin
      busy     <= (state_nx != ST_IDLE);
      rd_valid <= beat_lo | beat_hi;
      ad_oe    <= beat_lo | beat_hi;
      done     <= beat_hi | (state_nx == ST_WR_ACK);
      if (beat_lo)      ad_out <= word[BUS_W-1:0];
      else if (beat_hi) ad_out <= word[WORD_W-1:BUS_W];
      else              ad_out <= '0;
    end
  end

endmodule

// File: rtl/mux_bus_mem_target.sv
`timescale 1ns/1ps
module mux_bus_mem_target
  import mbt_pkg::*;
#(
  parameter int BUS_W      = 32,
  parameter int DEPTH      = 16,
  parameter int ACCESS_CYC = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             cmd_wr,
  input  logic [BUS_W-1:0] ad_in,
  output logic [BUS_W-1:0] ad_out,
  output logic             ad_oe,
  output logic             rd_valid,
  output logic             done,
  output logic             busy
);

  localparam int WORD_W  = 2 * BUS_W;
  localparam int IDX_W   = $clog2(DEPTH);
  localparam int BYTE_SH = $clog2(WORD_W / 8);

  mbt_state_e state, state_nx;
  logic accept;

  logic [IDX_W-1:0]  idx_q;
  logic [BUS_W-1:0]  lo_q;
  logic [WORD_W-1:0] rd_word;
  logic              ram_en, ram_we;

  mbt_seq #(.ACCESS_CYC(ACCESS_CYC)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .cmd_wr   (cmd_wr),
    .state    (state),
    .state_nx (state_nx),
    .accept   (accept)
  );

  // Address and low write half are captured off the shared lines.
  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      lo_q  <= '0;
    end else begin
      if (accept)             idx_q <= ad_in[BYTE_SH +: IDX_W];
      if (state == ST_WR_LO)  lo_q  <= ad_in;
    end
  end

  always_comb begin
    ram_en = (state == ST_WAIT) || (state == ST_WR_HI);
    ram_we = (state == ST_WR_HI);
  end

  mbt_word_ram #(.WORD_W(WORD_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_ram (
    .clk   (clk),
    .en    (ram_en),
    .we    (ram_we),
    .idx   (idx_q),
    .wdata ({ad_in, lo_q}),
    .rdata (rd_word)
  );

  mbt_bus_stage #(.BUS_W(BUS_W), .WORD_W(WORD_W)) u_bus (
    .clk      (clk),
    .rst      (rst),
    .state_nx (state_nx),
    .word     (rd_word),
    .ad_out   (ad_out),
    .ad_oe    (ad_oe),
    .rd_valid (rd_valid),
    .done     (done),
    .busy     (busy)
  );

endmodule

// File: rtl/mbt_check.sv
`timescale 1ns/1ps
module mbt_check #(
  parameter int ACCESS_CYC = 5
) (
  input logic clk,
  input logic rst,
  input logic req,
  input logic rd_valid,
  input logic done,
  input logic ad_oe,
  input logic busy
);

  localparam int CW = $clog2(ACCESS_CYC + 4) + 1;
  localparam logic [CW-1:0] FIRST_BEAT = CW'(ACCESS_CYC + 1);
  localparam logic [CW-1:0] WR_DONE    = CW'(3);

  // Cycle number within the current transaction, 1 right after acceptance.
  logic [CW-1:0] since;
  always_ff @(posedge clk) begin
    if (rst)                        since <= '0;
    else if (req && !busy)          since <= CW'(1);
    else if (busy && since != '1)   since <= since + 1'b1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!busy && !rd_valid && !done && !ad_oe));

  a_r2_busy_needs_req: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req));

  a_r4_first_beat_cycle: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !done) |-> (since == FIRST_BEAT));

  a_r5_second_beat_follows: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !done) |=> (rd_valid && done));

  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r6_write_done_cycle: assert property (@(posedge clk) disable iff (rst)
    (done && !rd_valid) |-> (since == WR_DONE));

  a_r8_drive_only_busy: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> busy);

endmodule

bind mux_bus_mem_target mbt_check #(.ACCESS_CYC(ACCESS_CYC)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req      (req),
  .rd_valid (rd_valid),
  .done     (done),
  .ad_oe    (ad_oe),
  .busy     (busy)
);

// File: tb/mux_bus_mem_target_test.sv
`timescale 1ns/1ps
module mux_bus_mem_target_test;

  localparam int BUS_W = 32;
  localparam int DEPTH = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req = 1'b0;
  logic             cmd_wr = 1'b0;
  logic [BUS_W-1:0] ad_in = '0;
  logic [BUS_W-1:0] ad_out;
  logic             ad_oe, rd_valid, done, busy;

  int checks = 0;
  int fails  = 0;
  logic [63:0] model [DEPTH];

  always #2 clk = ~clk;  // 250 MHz

  mux_bus_mem_target #(.BUS_W(BUS_W), .DEPTH(DEPTH), .ACCESS_CYC(5)) uut (
    .clk(clk), .rst(rst), .req(req), .cmd_wr(cmd_wr), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .rd_valid(rd_valid), .done(done), .busy(busy)
  );

  function automatic int word_of(input logic [31:0] addr);
    return int'((addr >> 3) & (DEPTH - 1));
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // inject: raise a read request during the write data cycles (R9)
  task automatic wr_txn(input logic [31:0] addr, input logic [63:0] data, input bit inject);
    @(negedge clk); req = 1'b1; cmd_wr = 1'b1; ad_in = addr;
    @(negedge clk);                       // cycle 1
    chk("R2 busy in write", {63'd0, busy}, 64'd1);
    req = inject; cmd_wr = 1'b0; ad_in = data[31:0];
    @(negedge clk);                       // cycle 2
    chk("R8 no drive during write data", {63'd0, ad_oe}, 64'd0);
    req = inject; ad_in = data[63:32];
    @(negedge clk);                       // cycle 3
    req = 1'b0; ad_in = $urandom;
    chk("R6 write done cycle 3", {63'd0, done}, 64'd1);
    chk("R8 no valid in write", {63'd0, rd_valid}, 64'd0);
    @(negedge clk);                       // cycle 4
    chk("R7 write idle in cycle 4", {62'd0, busy, done}, 64'd0);
    model[word_of(addr)] = data;
  endtask

  // inject: raise a write request with junk_addr during the access window (R9)
  task automatic rd_txn(input logic [31:0] addr, input bit inject, input logic [31:0] junk_addr);
    logic [63:0] exp;
    exp = model[word_of(addr)];
    @(negedge clk); req = 1'b1; cmd_wr = 1'b0; ad_in = addr;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      req = 1'b0; ad_in = $urandom;
      if (inject && (k == 2 || k == 6)) begin
        req = 1'b1; cmd_wr = 1'b1; ad_in = junk_addr;
      end
      if (k <= 5) begin
        chk("R4 no beat during access", {62'd0, rd_valid, busy}, 64'd1);
        chk("R8 lines released during access", {63'd0, ad_oe}, 64'd0);
      end else if (k == 6) begin
        chk("R5 low beat data", {32'd0, ad_out}, {32'd0, exp[31:0]});
        chk("R4 R8 low beat flags", {61'd0, rd_valid, ad_oe, done}, 64'd6);
      end else if (k == 7) begin
        chk("R5 high beat data", {32'd0, ad_out}, {32'd0, exp[63:32]});
        chk("R6 read done on high beat", {61'd0, rd_valid, ad_oe, done}, 64'd7);
      end else begin
        chk("R4 idle in cycle 8", {60'd0, busy, rd_valid, ad_oe, done}, 64'd0);
      end
    end
    cmd_wr = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset outputs", {60'd0, busy, rd_valid, ad_oe, done}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", {60'd0, busy, rd_valid, ad_oe, done}, 64'd0);

    for (int i = 0; i < DEPTH; i++)
      wr_txn(32'(i) << 3, {$urandom, $urandom}, 1'b0);

    // R3: aliased addresses reach the same word
    wr_txn(32'hFFFF_FF9F, 64'h0123_4567_89AB_CDEF, 1'b0);  // word 3
    rd_txn(32'h0000_0018, 1'b0, 32'd0);
    rd_txn(32'h8000_001D, 1'b0, 32'd0);

    // R9: write request injected into a read must not touch word 9
    rd_txn(32'h0000_0020, 1'b1, 32'h0000_0048);
    rd_txn(32'h0000_0048, 1'b0, 32'd0);

    // R9: read request injected into write data cycles
    wr_txn(32'h0000_0050, 64'hFFFF_0000_AAAA_5555, 1'b1);
    rd_txn(32'h0000_0050, 1'b0, 32'd0);

    // boundary patterns on last word
    wr_txn(32'h0000_0078, 64'hFFFF_FFFF_0000_0000, 1'b0);
    rd_txn(32'h0000_0078, 1'b0, 32'd0);
    wr_txn(32'h0000_0078, 64'h0000_0000_FFFF_FFFF, 1'b0);
    rd_txn(32'h0000_0078, 1'b0, 32'd0);

    // random mix (R7 stored words read back)
    for (int n = 0; n < 60; n++) begin
      if ($urandom_range(1, 0) == 1)
        wr_txn($urandom, {$urandom, $urandom}, 1'($urandom_range(1, 0)));
      else
        rd_txn($urandom, 1'($urandom_range(1, 0)), $urandom);
    end

    summary();
    $finish;
  end

  initial begin
    #800000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

endmodule